// File: doc/BRIEF.md
# I2C Controller Status Flag Tracker

This block holds the status and interrupt flags of an I2C controller that can work as bus master or as addressed slave. A separate bit-level engine watches SCL and SDA and sends single-cycle event strobes: a start the controller issued, a start another master made, a stop, the end of a byte together with the acknowledge bit received, a lost arbitration, and the three address-match kinds (own address, general call, second address). The tracker turns these strobes into sticky flags, data-ready flags, one interrupt flag and a transfer-request line for a DMA engine. Software clears sticky flags by writing a clear strobe with a bit mask.

A five-state controller follows the bus role. ST_IDLE goes to ST_MASTER on a start the controller issued and to ST_LISTEN on a start seen from another master. ST_MASTER goes to ST_LISTEN on lost arbitration, or straight to ST_ADDR or ST_ADDR2 if an address match comes in the same cycle. ST_LISTEN goes to ST_ADDR on an own-address or general-call match and to ST_ADDR2 on a second-address match. ST_ADDR and ST_ADDR2 go back to ST_LISTEN on a repeated start. A stop sends every state to ST_IDLE, and a start the controller issues sends every state to ST_MASTER. These two rules outrank all the others, stop first. While the state is ST_ADDR, byte completions do not raise the transfer request.

The interrupt flag and the transfer-request flag are kept apart from the data-ready flags. Data register accesses clear only the data-ready flags. The interrupt flag clears only when software writes a clear. The transfer-request flag clears when software writes a clear or when a new start arrives.

Top module: `i2c_flag_track`

## Requirements
- R1: After reset, and while reset is held, every output is 0 and the controller is in ST_IDLE.
- R2: One cycle after a start the controller issued, is_master, is_xmit and bus_busy read 1. One cycle after a start from another master, bus_busy reads 1 and is_master and is_xmit read 0.
- R3: One cycle after a stop, bus_busy, is_master and is_xmit read 0 and stop_seen reads 1. stop_early also reads 1 if stop_partial was high with the stop. Any new start clears both stop flags.
- R4: One cycle after lost arbitration, arb_lost reads 1, is_master and is_xmit read 0, and bus_busy stays 1.
- R5: An own-address match sets addr_hit. A general-call match sets both addr_hit and gcall_hit. A second-address match sets addr2_hit. Any of the three loads is_xmit from rw_bit.
- R6: On a byte completion, ack_in loads ack_bit. tx_empty is set if is_xmit is 1, otherwise rx_full is set. A data write clears tx_empty and a data read clears rx_full. Neither access changes irq_flag or xfer_req.
- R7: A byte completion sets xfer_req, except in ST_ADDR, which runs from an own-address or general-call match until the next repeated start or stop. After a second-address match, or after a repeated start, byte completions set xfer_req again.
- R8: irq_flag is set by a byte completion, lost arbitration, any address match or a stop. After that it stays 1 until a clear write with mask bit 0.
- R9: A clear write drops each sticky flag whose mask bit is 1. The bit order is: 0 irq_flag, 1 xfer_req, 2 stop_seen, 3 stop_early, 4 arb_lost, 5 addr_hit, 6 gcall_hit, 7 addr2_hit. If a set event and a clear hit the same flag in one cycle, the set wins.
- R10: req_out is 1 exactly when xfer_req and req_en are both 1. Any new start clears xfer_req unless a byte completion comes in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ev_start_issue | input | 1 | Strobe: this controller issued a start |
| ev_start_seen | input | 1 | Strobe: start from another master detected |
| ev_stop | input | 1 | Strobe: stop detected |
| stop_partial | input | 1 | Qualifies ev_stop: the stop cut a frame short |
| ev_byte_done | input | 1 | Strobe: a byte and its acknowledge bit finished |
| ack_bit | input | 1 | Acknowledge bit sampled with ev_byte_done |
| ev_arb_lost | input | 1 | Strobe: arbitration lost |
| ev_own_match | input | 1 | Strobe: own slave address matched |
| ev_gcall | input | 1 | Strobe: general-call address matched |
| ev_addr2_match | input | 1 | Strobe: second slave address matched |
| rw_bit | input | 1 | Direction bit of the matched address frame (1 means the slave transmits) |
| dr_wr | input | 1 | Strobe: software wrote the data register |
| dr_rd | input | 1 | Strobe: software read the data register |
| clr_wr | input | 1 | Strobe: software clear write |
| clr_mask | input | 8 | Sticky flags to clear, one bit per flag (see R9) |
| req_en | input | 1 | Enables the transfer request output |
| is_master | output | 1 | Controller is bus master |
| is_xmit | output | 1 | Controller is the transmitter |
| bus_busy | output | 1 | Bus is between a start and a stop |
| stop_seen | output | 1 | Stop detected |
| stop_early | output | 1 | Stop cut a frame short |
| xfer_req | output | 1 | Transfer request flag |
| addr2_hit | output | 1 | Second address matched |
| arb_lost | output | 1 | Arbitration lost |
| addr_hit | output | 1 | Own or general-call address matched |
| gcall_hit | output | 1 | General-call address matched |
| ack_in | output | 1 | Last acknowledge bit received |
| tx_empty | output | 1 | Transmit data register empty |
| rx_full | output | 1 | Receive data register full |
| irq_flag | output | 1 | Interrupt flag |
| req_out | output | 1 | Transfer request line to the DMA engine |

## Verification
Every flag is a register, so each event strobe shows up exactly one clock edge after the cycle it is driven in. The role flags come from the controller state and have the same single-edge delay. The one exception is req_out, which is a combinational AND of a registered flag and req_en. It therefore follows req_en within the same cycle and follows xfer_req one edge after its cause. The bench drives each stimulus row on a falling edge, lets one rising edge pass, and compares all fifteen outputs on the next falling edge. At that point the row's own req_en is still applied, so every result is sampled in the cycle it is due.

// File: rtl/i2c_flag_pkg.sv
package i2c_flag_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MASTER,
        ST_LISTEN,
        ST_ADDR,
        ST_ADDR2
    } ctl_state_e;

    // sticky flag positions, also the clear-mask bit order
    localparam int NUM_STICKY = 8;
    localparam int SB_IRQ   = 0;
    localparam int SB_REQ   = 1;
    localparam int SB_STOP  = 2;
    localparam int SB_ESTOP = 3;
    localparam int SB_ARB   = 4;
    localparam int SB_AHIT  = 5;
    localparam int SB_GCALL = 6;
    localparam int SB_A2HIT = 7;

endpackage

// File: rtl/i2c_flag_fsm.sv
module i2c_flag_fsm
    import i2c_flag_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ev_start_issue,
    input  logic ev_start_seen,
    input  logic ev_stop,
    input  logic ev_arb_lost,
    input  logic ev_own_match,
    input  logic ev_gcall,
    input  logic ev_addr2_match,
    output logic is_master,
    output logic bus_busy,
    output logic req_hold
);

    ctl_state_e cur_q;
    ctl_state_e nxt;
    logic       prim_hit;

    assign prim_hit = ev_own_match | ev_gcall;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= ST_IDLE;
        end else begin
            cur_q <= nxt;
        end
    end

    // next state: stop first, then an issued start, then per-state rules
    always_comb begin
        nxt = cur_q;
        if (ev_stop) begin
            nxt = ST_IDLE;
        end else if (ev_start_issue) begin
            nxt = ST_MASTER;
        end else begin
            unique case (cur_q)
                ST_IDLE: begin
                    if (ev_start_seen) nxt = ST_LISTEN;
                end
                ST_MASTER: begin
                    if (ev_arb_lost) begin
                        if (prim_hit)            nxt = ST_ADDR;
                        else if (ev_addr2_match) nxt = ST_ADDR2;
                        else                     nxt = ST_LISTEN;
                    end
                end
                ST_LISTEN: begin
                    if (ev_start_seen)       nxt = ST_LISTEN;
                    else if (prim_hit)       nxt = ST_ADDR;
                    else if (ev_addr2_match) nxt = ST_ADDR2;
                end
                ST_ADDR, ST_ADDR2: begin
                    if (ev_start_seen) nxt = ST_LISTEN;
                end
                default: nxt = ST_IDLE;
            endcase
        end
    end

    // outputs from the state
    always_comb begin
        is_master = (cur_q == ST_MASTER);
        bus_busy  = (cur_q != ST_IDLE);
        req_hold  = (cur_q == ST_ADDR);
    end

endmodule

// File: rtl/i2c_sticky_bank.sv
module i2c_sticky_bank #(
    parameter int NBITS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NBITS-1:0] set_vec,
    input  logic [NBITS-1:0] clr_vec,
    output logic [NBITS-1:0] flag_q
);

    // one sticky bit per flag; a set event beats a clear
    for (genvar gi = 0; gi < NBITS; gi++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                flag_q[gi] <= 1'b0;
            end else if (set_vec[gi]) begin
                flag_q[gi] <= 1'b1;
            end else if (clr_vec[gi]) begin
                flag_q[gi] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/i2c_data_ready.sv
module i2c_data_ready (
    input  logic clk,
    input  logic rst_n,
    input  logic byte_done,
    input  logic ack_bit,
    input  logic xmit,
    input  logic dr_wr,
    input  logic dr_rd,
    output logic ack_in,
    output logic tx_empty,
    output logic rx_full
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ack_in <= 1'b0;
        end else if (byte_done) begin
            ack_in <= ack_bit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_empty <= 1'b0;
        end else if (byte_done && xmit) begin
            tx_empty <= 1'b1;
        end else if (dr_wr) begin
            tx_empty <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_full <= 1'b0;
        end else if (byte_done && !xmit) begin
            rx_full <= 1'b1;
        end else if (dr_rd) begin
            rx_full <= 1'b0;
        end
    end

endmodule

// File: rtl/i2c_flag_track.sv
module i2c_flag_track
    import i2c_flag_pkg::*;
#(
    parameter int MASK_W = NUM_STICKY
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_start_issue,
    input  logic              ev_start_seen,
    input  logic              ev_stop,
    input  logic              stop_partial,
    input  logic              ev_byte_done,
    input  logic              ack_bit,
    input  logic              ev_arb_lost,
    input  logic              ev_own_match,
    input  logic              ev_gcall,
    input  logic              ev_addr2_match,
    input  logic              rw_bit,
    input  logic              dr_wr,
    input  logic              dr_rd,
    input  logic              clr_wr,
    input  logic [MASK_W-1:0] clr_mask,
    input  logic              req_en,
    output logic              is_master,
    output logic              is_xmit,
    output logic              bus_busy,
    output logic              stop_seen,
    output logic              stop_early,
    output logic              xfer_req,
    output logic              addr2_hit,
    output logic              arb_lost,
    output logic              addr_hit,
    output logic              gcall_hit,
    output logic              ack_in,
    output logic              tx_empty,
    output logic              rx_full,
    output logic              irq_flag,
    output logic              req_out
);

    logic                  req_hold;
    logic                  start_any;
    logic                  any_match;
    logic [MASK_W-1:0]     set_vec;
    logic [MASK_W-1:0]     clr_vec;
    logic [MASK_W-1:0]     sticky_q;
    logic                  xmit_q;

    assign start_any = ev_start_issue | ev_start_seen;
    assign any_match = ev_own_match | ev_gcall | ev_addr2_match;

    i2c_flag_fsm u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .ev_start_issue (ev_start_issue),
        .ev_start_seen  (ev_start_seen),
        .ev_stop        (ev_stop),
        .ev_arb_lost    (ev_arb_lost),
        .ev_own_match   (ev_own_match),
        .ev_gcall       (ev_gcall),
        .ev_addr2_match (ev_addr2_match),
        .is_master      (is_master),
        .bus_busy       (bus_busy),
        .req_hold       (req_hold)
    );

    // set and clear sources of the sticky flags
    always_comb begin
        set_vec           = '0;
        set_vec[SB_IRQ]   = ev_byte_done | ev_arb_lost | any_match | ev_stop;
        set_vec[SB_REQ]   = ev_byte_done & ~req_hold;
        set_vec[SB_STOP]  = ev_stop;
        set_vec[SB_ESTOP] = ev_stop & stop_partial;
        set_vec[SB_ARB]   = ev_arb_lost;
        set_vec[SB_AHIT]  = ev_own_match | ev_gcall;
        set_vec[SB_GCALL] = ev_gcall;
        set_vec[SB_A2HIT] = ev_addr2_match;

        clr_vec           = clr_wr ? clr_mask : '0;
        clr_vec[SB_REQ]   = clr_vec[SB_REQ]   | start_any;
        clr_vec[SB_STOP]  = clr_vec[SB_STOP]  | start_any;
        clr_vec[SB_ESTOP] = clr_vec[SB_ESTOP] | start_any;
    end

    i2c_sticky_bank #(.NBITS(MASK_W)) u_sticky (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .flag_q  (sticky_q)
    );

    // transmitter role
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            xmit_q <= 1'b0;
        end else if (ev_stop) begin
            xmit_q <= 1'b0;
        end else if (ev_start_issue) begin
            xmit_q <= 1'b1;
        end else if (ev_start_seen) begin
            xmit_q <= 1'b0;
        end else if (any_match) begin
            xmit_q <= rw_bit;
        end else if (ev_arb_lost) begin
            xmit_q <= 1'b0;
        end
    end

    i2c_data_ready u_dready (
        .clk       (clk),
        .rst_n     (rst_n),
        .byte_done (ev_byte_done),
        .ack_bit   (ack_bit),
        .xmit      (xmit_q),
        .dr_wr     (dr_wr),
        .dr_rd     (dr_rd),
        .ack_in    (ack_in),
        .tx_empty  (tx_empty),
        .rx_full   (rx_full)
    );

    assign is_xmit    = xmit_q;
    assign irq_flag   = sticky_q[SB_IRQ];
    assign xfer_req   = sticky_q[SB_REQ];
    assign stop_seen  = sticky_q[SB_STOP];
    assign stop_early = sticky_q[SB_ESTOP];
    assign arb_lost   = sticky_q[SB_ARB];
    assign addr_hit   = sticky_q[SB_AHIT];
    assign gcall_hit  = sticky_q[SB_GCALL];
    assign addr2_hit  = sticky_q[SB_A2HIT];
    assign req_out    = xfer_req & req_en;

endmodule

// File: rtl/i2c_flag_track_chk.sv
module i2c_flag_track_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ev_start_issue,
    input logic       ev_start_seen,
    input logic       ev_stop,
    input logic       ev_byte_done,
    input logic       ack_bit,
    input logic       ev_arb_lost,
    input logic       ev_gcall,
    input logic       clr_wr,
    input logic [7:0] clr_mask,
    input logic       is_master,
    input logic       is_xmit,
    input logic       bus_busy,
    input logic       stop_seen,
    input logic       xfer_req,
    input logic       arb_lost,
    input logic       addr_hit,
    input logic       gcall_hit,
    input logic       ack_in,
    input logic       irq_flag
);

    p_idle_not_master_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_busy |-> !is_master);

    p_stop_frees_bus_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ev_stop |=> (!bus_busy && stop_seen && !is_xmit));

    p_arb_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_arb_lost && !ev_stop && !ev_start_issue) |=> (!is_master && arb_lost));

    p_gcall_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ev_gcall |=> (addr_hit && gcall_hit));

    p_ack_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ev_byte_done |=> (ack_in == $past(ack_bit)));

    p_irq_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flag && !(clr_wr && clr_mask[0])) |=> irq_flag);

    p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_byte_done && clr_wr && clr_mask[0]) |=> irq_flag);

    p_start_drops_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((ev_start_issue || ev_start_seen) && !ev_byte_done) |=> !xfer_req);

endmodule

bind i2c_flag_track i2c_flag_track_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .ev_start_issue (ev_start_issue),
    .ev_start_seen  (ev_start_seen),
    .ev_stop        (ev_stop),
    .ev_byte_done   (ev_byte_done),
    .ack_bit        (ack_bit),
    .ev_arb_lost    (ev_arb_lost),
    .ev_gcall       (ev_gcall),
    .clr_wr         (clr_wr),
    .clr_mask       (clr_mask),
    .is_master      (is_master),
    .is_xmit        (is_xmit),
    .bus_busy       (bus_busy),
    .stop_seen      (stop_seen),
    .xfer_req       (xfer_req),
    .arb_lost       (arb_lost),
    .addr_hit       (addr_hit),
    .gcall_hit      (gcall_hit),
    .ack_in         (ack_in),
    .irq_flag       (irq_flag)
);

// File: tb/i2c_flag_track_bench.sv
module i2c_flag_track_bench;

    // stimulus bits
    localparam logic [13:0] E_SI   = 14'd1 << 13;
    localparam logic [13:0] E_SS   = 14'd1 << 12;
    localparam logic [13:0] E_SP   = 14'd1 << 11;
    localparam logic [13:0] E_PART = 14'd1 << 10;
    localparam logic [13:0] E_BD   = 14'd1 << 9;
    localparam logic [13:0] E_ACK  = 14'd1 << 8;
    localparam logic [13:0] E_AL   = 14'd1 << 7;
    localparam logic [13:0] E_OWN  = 14'd1 << 6;
    localparam logic [13:0] E_GC   = 14'd1 << 5;
    localparam logic [13:0] E_A2   = 14'd1 << 4;
    localparam logic [13:0] E_RW   = 14'd1 << 3;
    localparam logic [13:0] E_DW   = 14'd1 << 2;
    localparam logic [13:0] E_DR   = 14'd1 << 1;
    localparam logic [13:0] E_CLR  = 14'd1 << 0;

    // observed output bits
    localparam logic [14:0] O_MST  = 15'd1 << 14;
    localparam logic [14:0] O_XMT  = 15'd1 << 13;
    localparam logic [14:0] O_BSY  = 15'd1 << 12;
    localparam logic [14:0] O_STP  = 15'd1 << 11;
    localparam logic [14:0] O_EST  = 15'd1 << 10;
    localparam logic [14:0] O_REQ  = 15'd1 << 9;
    localparam logic [14:0] O_A2   = 15'd1 << 8;
    localparam logic [14:0] O_AL   = 15'd1 << 7;
    localparam logic [14:0] O_AAS  = 15'd1 << 6;
    localparam logic [14:0] O_GC   = 15'd1 << 5;
    localparam logic [14:0] O_ACK  = 15'd1 << 4;
    localparam logic [14:0] O_TXE  = 15'd1 << 3;
    localparam logic [14:0] O_RXF  = 15'd1 << 2;
    localparam logic [14:0] O_IRQ  = 15'd1 << 1;
    localparam logic [14:0] O_ROUT = 15'd1 << 0;

    typedef struct packed {
        logic [13:0] ev;
        logic [7:0]  mask;
        logic        ren;
        logic [14:0] expv;
    } vec_t;

    localparam int NV = 25;
    localparam vec_t TABLE [NV] = '{
        '{14'd0, 8'h00, 1'b0, 15'd0},                                                   // 0 idle R1
        '{E_SI, 8'h00, 1'b0, O_MST|O_XMT|O_BSY},                                        // 1 start issued R2
        '{E_BD|E_ACK, 8'h00, 1'b1, O_MST|O_XMT|O_BSY|O_REQ|O_ACK|O_TXE|O_IRQ|O_ROUT},  // 2 master end R6
        '{E_DW, 8'h00, 1'b1, O_MST|O_XMT|O_BSY|O_REQ|O_ACK|O_IRQ|O_ROUT},              // 3 write keeps irq R6
        '{14'd0, 8'h00, 1'b0, O_MST|O_XMT|O_BSY|O_REQ|O_ACK|O_IRQ},                    // 4 enable gate R10
        '{E_CLR, 8'h03, 1'b0, O_MST|O_XMT|O_BSY|O_ACK},                                // 5 clear irq R8
        '{E_AL, 8'h00, 1'b0, O_BSY|O_ACK|O_AL|O_IRQ},                                  // 6 arb lost R4
        '{E_OWN|E_RW, 8'h00, 1'b0, O_BSY|O_XMT|O_ACK|O_AL|O_AAS|O_IRQ},                // 7 own match R5
        '{E_CLR, 8'h11, 1'b0, O_BSY|O_XMT|O_ACK|O_AAS},                                // 8 mask clear R9
        '{E_BD, 8'h00, 1'b1, O_BSY|O_XMT|O_AAS|O_TXE|O_IRQ},                           // 9 req held R7
        '{E_SS, 8'h00, 1'b1, O_BSY|O_AAS|O_TXE|O_IRQ},                                 // 10 restart R2
        '{E_BD, 8'h00, 1'b1, O_BSY|O_AAS|O_TXE|O_RXF|O_IRQ|O_REQ|O_ROUT},              // 11 req back R7
        '{E_DR, 8'h00, 1'b1, O_BSY|O_AAS|O_TXE|O_IRQ|O_REQ|O_ROUT},                    // 12 read R6
        '{E_SP|E_PART, 8'h00, 1'b1, O_AAS|O_TXE|O_IRQ|O_REQ|O_ROUT|O_STP|O_EST},       // 13 stop R3
        '{E_CLR, 8'hFF, 1'b0, O_TXE},                                                   // 14 clear all R9
        '{E_SS, 8'h00, 1'b0, O_BSY|O_TXE},                                              // 15 start seen R2
        '{E_GC, 8'h00, 1'b0, O_BSY|O_TXE|O_AAS|O_GC|O_IRQ},                            // 16 gcall R5
        '{E_BD, 8'h00, 1'b1, O_BSY|O_TXE|O_AAS|O_GC|O_IRQ|O_RXF},                      // 17 slave end R7
        '{E_SP, 8'h00, 1'b0, O_TXE|O_AAS|O_GC|O_IRQ|O_RXF|O_STP},                      // 18 stop R3
        '{E_SS, 8'h00, 1'b0, O_BSY|O_TXE|O_AAS|O_GC|O_IRQ|O_RXF},                      // 19 start clears stop R3
        '{E_A2, 8'h00, 1'b0, O_BSY|O_TXE|O_AAS|O_GC|O_IRQ|O_RXF|O_A2},                 // 20 second addr R5
        '{E_BD, 8'h00, 1'b1, O_BSY|O_TXE|O_AAS|O_GC|O_IRQ|O_RXF|O_A2|O_REQ|O_ROUT},    // 21 slave end R7
        '{E_BD|E_CLR, 8'h03, 1'b1, O_BSY|O_TXE|O_AAS|O_GC|O_IRQ|O_RXF|O_A2|O_REQ|O_ROUT}, // 22 set wins R9
        '{E_SI, 8'h00, 1'b1, O_MST|O_XMT|O_BSY|O_TXE|O_AAS|O_GC|O_IRQ|O_RXF|O_A2},     // 23 start drops req R10
        '{E_SP, 8'h00, 1'b1, O_TXE|O_AAS|O_GC|O_IRQ|O_RXF|O_A2|O_STP}                  // 24 stop R3
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ev_start_issue = 0, ev_start_seen = 0, ev_stop = 0, stop_partial = 0;
    logic ev_byte_done = 0, ack_bit = 0, ev_arb_lost = 0, ev_own_match = 0;
    logic ev_gcall = 0, ev_addr2_match = 0, rw_bit = 0, dr_wr = 0, dr_rd = 0;
    logic clr_wr = 0, req_en = 0;
    logic [7:0] clr_mask = 8'h00;
    logic is_master, is_xmit, bus_busy, stop_seen, stop_early, xfer_req;
    logic addr2_hit, arb_lost, addr_hit, gcall_hit, ack_in, tx_empty, rx_full;
    logic irq_flag, req_out;
    int   total = 0;
    int   bad = 0;
    logic done = 1'b0;

    always #10 clk = ~clk;

    i2c_flag_track u_i2c_flag_track (
        .clk(clk), .rst_n(rst_n),
        .ev_start_issue(ev_start_issue), .ev_start_seen(ev_start_seen),
        .ev_stop(ev_stop), .stop_partial(stop_partial),
        .ev_byte_done(ev_byte_done), .ack_bit(ack_bit),
        .ev_arb_lost(ev_arb_lost), .ev_own_match(ev_own_match),
        .ev_gcall(ev_gcall), .ev_addr2_match(ev_addr2_match), .rw_bit(rw_bit),
        .dr_wr(dr_wr), .dr_rd(dr_rd), .clr_wr(clr_wr), .clr_mask(clr_mask),
        .req_en(req_en),
        .is_master(is_master), .is_xmit(is_xmit), .bus_busy(bus_busy),
        .stop_seen(stop_seen), .stop_early(stop_early), .xfer_req(xfer_req),
        .addr2_hit(addr2_hit), .arb_lost(arb_lost), .addr_hit(addr_hit),
        .gcall_hit(gcall_hit), .ack_in(ack_in), .tx_empty(tx_empty),
        .rx_full(rx_full), .irq_flag(irq_flag), .req_out(req_out)
    );

    function automatic logic [14:0] observed();
        return {is_master, is_xmit, bus_busy, stop_seen, stop_early, xfer_req,
                addr2_hit, arb_lost, addr_hit, gcall_hit, ack_in, tx_empty,
                rx_full, irq_flag, req_out};
    endfunction

    function automatic string tag_of(int idx);
        case (idx)
            0:                   return "R1";
            1, 10, 15:           return "R2";
            13, 18, 19, 24:      return "R3";
            6:                   return "R4";
            7, 16, 20:           return "R5";
            2, 3, 12:            return "R6";
            9, 11, 17, 21:       return "R7";
            5:                   return "R8";
            8, 14, 22:           return "R9";
            default:             return "R10";
        endcase
    endfunction

    task automatic apply(input vec_t v);
        {ev_start_issue, ev_start_seen, ev_stop, stop_partial, ev_byte_done,
         ack_bit, ev_arb_lost, ev_own_match, ev_gcall, ev_addr2_match,
         rw_bit, dr_wr, dr_rd, clr_wr} = v.ev;
        clr_mask = v.mask;
        req_en   = v.ren;
    endtask

    task automatic check(input string tag, input logic [14:0] expv, input string what);
        total++;
        if (observed() !== expv) begin
            bad++;
            $display("FAIL %s %s: actual=%b expected=%b", tag, what, observed(), expv);
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1: outputs while reset is held
        repeat (3) @(negedge clk);
        check("R1", 15'd0, "held in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", 15'd0, "after reset release");

        for (int i = 0; i < NV; i++) begin
            apply(TABLE[i]);
            @(negedge clk);
            check(tag_of(i), TABLE[i].expv, $sformatf("row %0d", i));
        end
        apply('0);

        // R1: reset mid-run drops every flag
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", 15'd0, "reset mid-run");
        rst_n = 1'b1;
        @(negedge clk);

        // R4 corner: arbitration lost together with own match goes addressed
        apply('{E_SI, 8'h00, 1'b0, 15'd0});
        @(negedge clk);
        apply('{E_AL|E_OWN, 8'h00, 1'b1, 15'd0});
        @(negedge clk);
        check("R4", O_BSY|O_AL|O_AAS|O_IRQ, "arb lost with own match");
        apply('{E_BD, 8'h00, 1'b1, 15'd0});
        @(negedge clk);
        check("R7", O_BSY|O_AL|O_AAS|O_IRQ|O_RXF, "req held after arb-lost match");

        // R3: stop without partial leaves stop_early clear
        apply('{E_SP, 8'h00, 1'b1, 15'd0});
        @(negedge clk);
        check("R3", O_STP|O_AL|O_AAS|O_IRQ|O_RXF, "plain stop");
        apply('0);
        @(negedge clk);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule